// File: doc/BRIEF.md
# Pipelined Neville Cubic Interpolator

This block evaluates the cubic polynomial through four sample points at a query position, using Neville's recursive tableau. Each point arrives as two 64-bit words, one holding the four x coordinates and one holding the four y values, together with a 16-bit query position. The block produces one signed 16-bit result with a valid flag and an error flag.

The tableau is evaluated in dependency order. A first register stage forms the query offsets and the node spacings. Three cell levels follow, holding three, two and one cell. Each cell computes a cross product difference and divides it by a node spacing in a fully pipelined restoring divider. The offsets and spacings that later levels need travel in delay lines beside the cells. A new point can be accepted on every clock, and the same hardware serves every point.

Top module: `nev_interp`

## Requirements
- R1: Lane i (0..3) of each 64-bit input word occupies bits [16*i+15:16*i]. Lane i of `x_word_i` is node x_i and lane i of `y_word_i` is its sample y_i. All lanes are two's-complement.
- R2: With d_i = q - x_i held exactly at 17 bits, each tableau entry is (left·d_far - right·d_near)/(x_near - x_far). The levels are p01, p12, p23, then p02, p13, then p03, and the output is p03. Every entry is truncated toward zero and then clamped to [-32768, 32767] before the next level uses it.
- R3: When the query equals one of the nodes, the result equals that node's sample.
- R4: If any two of the four x coordinates are equal, the result is 0 and `out_err_o` is 1 on the same cycle as `out_valid_o`.
- R5: If all four x coordinates are distinct, `out_err_o` is 0 with the result. `out_err_o` is never 1 while `out_valid_o` is 0.
- R6: With default parameters, a result appears on the outputs exactly 109 cycles after the clock edge that accepts its point (1 + 3·(2·DW+4)).
- R7: `in_ready_o` is always 1, so a point is accepted on every cycle that `in_valid_i` is 1. Exactly one result is produced per accepted point, in acceptance order.
- R8: During and right after reset, `out_valid_o`, `out_err_o` and `out_data_o` are 0.
- R9: A final value outside the 16-bit range is clamped to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A point is presented |
| in_ready_o | output | 1 | The block accepts a point (always 1) |
| x_word_i | input | 64 | Four packed x coordinates |
| y_word_i | input | 64 | Four packed y samples |
| xq_i | input | 16 | Query position |
| out_valid_o | output | 1 | A result is present |
| out_err_o | output | 1 | Duplicate x coordinates in that point |
| out_data_o | output | 16 | Interpolated value |

## Verification
Every result is due exactly 109 cycles after its acceptance edge: one offset stage plus three cells of 36 registers each. The bench stamps each accepted point with its cycle number and queues its expected value. It samples the outputs on the falling edge. A result counts as correct only if it arrives on exactly the stamped cycle plus 109. A valid that arrives early, late or unrequested is reported as a latency or ordering failure. Directed points cover node hits, duplicate nodes, lane order and clamping. They are followed by random bursts with idle gaps, so that results also appear while the pipeline is full.

// File: rtl/nev_pkg.sv
`timescale 1ns/1ps
package nev_pkg;
  localparam int unsigned NEV_DW = 16;
  localparam int unsigned NEV_LANES = 4;

  // cell latency: entry reg + one divider stage per numerator bit + output reg
  function automatic int unsigned cell_lat(input int unsigned dw);
    return 2 * dw + 4;
  endfunction
endpackage

// File: rtl/nev_delay.sv
`timescale 1ns/1ps
module nev_delay #(
  parameter int unsigned W = 8,
  parameter int unsigned D = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr_q [D];

  for (genvar k = 0; k < D; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[k] <= '0;
      else         sr_q[k] <= (k == 0) ? d_i : sr_q[(k == 0) ? 0 : k - 1];
    end
  end

  assign q_o = sr_q[D-1];
endmodule

// File: rtl/nev_div.sv
`timescale 1ns/1ps
module nev_div #(
  parameter int unsigned NW  = 34,
  parameter int unsigned DNW = 17,
  parameter int unsigned TW  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic [NW-1:0]  num_i,
  input  logic [DNW-1:0] den_i,
  input  logic [TW-1:0]  tag_i,
  output logic           vld_o,
  output logic [NW-1:0]  quo_o,
  output logic [TW-1:0]  tag_o
);
  for (genvar k = 0; k < NW; k++) begin : g_st
    logic           pv, v_q;
    logic [NW-1:0]  pnq, nq_q;   // remaining dividend bits shifted out, quotient bits shifted in
    logic [DNW-1:0] pr, pd, r_q, d_q, sub;
    logic [TW-1:0]  pt, t_q;
    logic [DNW:0]   t;
    logic           ge;

    if (k == 0) begin : g_first
      assign pv  = vld_i;
      assign pnq = num_i;
      assign pr  = '0;
      assign pd  = den_i;
      assign pt  = tag_i;
    end else begin : g_next
      assign pv  = g_st[k-1].v_q;
      assign pnq = g_st[k-1].nq_q;
      assign pr  = g_st[k-1].r_q;
      assign pd  = g_st[k-1].d_q;
      assign pt  = g_st[k-1].t_q;
    end

    assign t   = {pr, pnq[NW-1]};
    assign ge  = t >= {1'b0, pd};
    assign sub = t[DNW-1:0] - pd;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q  <= 1'b0;
        nq_q <= '0;
        r_q  <= '0;
        d_q  <= '0;
        t_q  <= '0;
      end else begin
        v_q  <= pv;
        nq_q <= {pnq[NW-2:0], ge};
        r_q  <= ge ? sub : t[DNW-1:0];
        d_q  <= pd;
        t_q  <= pt;
      end
    end

    // R2
    rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (v_q && d_q != '0) |-> (r_q < d_q));
  end

  assign vld_o = g_st[NW-1].v_q;
  assign quo_o = g_st[NW-1].nq_q;
  assign tag_o = g_st[NW-1].t_q;
endmodule

// File: rtl/nev_cell.sv
`timescale 1ns/1ps
module nev_cell #(
  parameter int unsigned DW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vld_i,
  input  logic                err_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [DW:0]   da_i,
  input  logic signed [DW:0]   db_i,
  input  logic signed [DW:0]   den_i,
  output logic                vld_o,
  output logic                err_o,
  output logic signed [DW-1:0] p_o
);
  localparam int unsigned DDW = DW + 1;
  localparam int unsigned PW  = DW + DDW;
  localparam int unsigned NW  = PW + 1;
  localparam logic [NW-1:0] POS_LIM = NW'((64'd1 << (DW - 1)) - 64'd1);
  localparam logic [NW-1:0] NEG_LIM = NW'(64'd1 << (DW - 1));

  logic signed [PW-1:0] pa, pb;
  logic signed [NW-1:0] num;
  logic [NW-1:0]  nmag;
  logic [DDW-1:0] dmag;

  assign pa   = $signed({{(PW-DW){a_i[DW-1]}}, a_i}) * $signed({{(PW-DDW){db_i[DDW-1]}}, db_i});
  assign pb   = $signed({{(PW-DW){b_i[DW-1]}}, b_i}) * $signed({{(PW-DDW){da_i[DDW-1]}}, da_i});
  assign num  = {pa[PW-1], pa} - {pb[PW-1], pb};
  assign nmag = num[NW-1] ? NW'(-num) : NW'(num);
  assign dmag = den_i[DDW-1] ? DDW'(-den_i) : DDW'(den_i);

  logic           v_q, e_q, n_q;
  logic [NW-1:0]  nm_q;
  logic [DDW-1:0] dm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0; e_q <= 1'b0; n_q <= 1'b0; nm_q <= '0; dm_q <= '0;
    end else begin
      v_q  <= vld_i;
      e_q  <= vld_i & (err_i | (den_i == '0));
      n_q  <= num[NW-1] ^ den_i[DDW-1];
      nm_q <= nmag;
      dm_q <= dmag;
    end
  end

  logic          dv;
  logic [NW-1:0] qm;
  logic [1:0]    dt;

  nev_div #(.NW(NW), .DNW(DDW), .TW(2)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (v_q),
    .num_i (nm_q),
    .den_i (dm_q),
    .tag_i ({e_q, n_q}),
    .vld_o (dv),
    .quo_o (qm),
    .tag_o (dt)
  );

  // truncated quotient magnitude -> signed, clamped
  logic signed [DW-1:0] sat;
  always_comb begin
    if (dt[0]) sat = (qm > NEG_LIM) ? $signed(NEG_LIM[DW-1:0]) : -$signed(qm[DW-1:0]);
    else       sat = (qm > POS_LIM) ? $signed(POS_LIM[DW-1:0]) :  $signed(qm[DW-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0; err_o <= 1'b0; p_o <= '0;
    end else begin
      vld_o <= dv;
      err_o <= dv & dt[1];
      p_o   <= (dv && !dt[1]) ? sat : '0;
    end
  end
endmodule

// File: rtl/nev_interp.sv
`timescale 1ns/1ps
module nev_interp
  import nev_pkg::*;
#(
  parameter int unsigned DW = NEV_DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [4*DW-1:0] x_word_i,
  input  logic [4*DW-1:0] y_word_i,
  input  logic [DW-1:0]   xq_i,
  output logic            out_valid_o,
  output logic            out_err_o,
  output logic [DW-1:0]   out_data_o
);
  localparam int unsigned DDW  = DW + 1;
  localparam int unsigned CLAT = cell_lat(DW);
  localparam int unsigned LAT  = 1 + 3 * CLAT;
  localparam int unsigned CW   = $clog2(LAT + 2);

  assign in_ready_o = 1'b1;

  // stage 1: unpack, query offsets, node spacings
  logic [DW-1:0]  x_l [NEV_LANES];
  logic [DW-1:0]  y_l [NEV_LANES];
  logic [DDW-1:0] d_c [NEV_LANES];
  for (genvar i = 0; i < NEV_LANES; i++) begin : g_lane
    assign x_l[i] = x_word_i[i*DW +: DW];
    assign y_l[i] = y_word_i[i*DW +: DW];
    assign d_c[i] = {xq_i[DW-1], xq_i} - {x_l[i][DW-1], x_l[i]};
  end

  function automatic logic [DDW-1:0] gap(input logic [DW-1:0] u, input logic [DW-1:0] v);
    return {u[DW-1], u} - {v[DW-1], v};
  endfunction

  logic                 s1_v;
  logic signed [DW-1:0] y_q [NEV_LANES];
  logic signed [DDW-1:0] d_q [NEV_LANES];
  logic signed [DDW-1:0] xa_q [3];
  logic signed [DDW-1:0] xb_q [2];
  logic signed [DDW-1:0] xc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0;
      xc_q <= '0;
      for (int i = 0; i < NEV_LANES; i++) begin
        y_q[i] <= '0;
        d_q[i] <= '0;
      end
      for (int i = 0; i < 3; i++) xa_q[i] <= '0;
      for (int i = 0; i < 2; i++) xb_q[i] <= '0;
    end else begin
      s1_v <= in_valid_i;
      for (int i = 0; i < NEV_LANES; i++) begin
        y_q[i] <= y_l[i];
        d_q[i] <= d_c[i];
      end
      for (int i = 0; i < 3; i++) xa_q[i] <= gap(x_l[i], x_l[i+1]);
      for (int i = 0; i < 2; i++) xb_q[i] <= gap(x_l[i], x_l[i+2]);
      xc_q <= gap(x_l[0], x_l[3]);
    end
  end

  // level A: p01, p12, p23
  logic                 va [3];
  logic                 ea [3];
  logic signed [DW-1:0] pa [3];
  for (genvar i = 0; i < 3; i++) begin : g_la
    nev_cell #(.DW(DW)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(s1_v), .err_i(1'b0),
      .a_i(y_q[i]), .b_i(y_q[i+1]), .da_i(d_q[i]), .db_i(d_q[i+1]),
      .den_i(xa_q[i]), .vld_o(va[i]), .err_o(ea[i]), .p_o(pa[i])
    );
  end

  // offsets and spacings for the later levels
  logic [7*DDW-1:0] dl1_q;
  nev_delay #(.W(7*DDW), .D(CLAT)) u_dl1 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({xc_q, xb_q[1], xb_q[0], d_q[3], d_q[2], d_q[1], d_q[0]}),
    .q_o(dl1_q)
  );
  logic signed [DDW-1:0] db_d [NEV_LANES];
  logic signed [DDW-1:0] xb_d [2];
  logic signed [DDW-1:0] xc_d1;
  for (genvar i = 0; i < NEV_LANES; i++) begin : g_db
    assign db_d[i] = dl1_q[i*DDW +: DDW];
  end
  assign xb_d[0] = dl1_q[4*DDW +: DDW];
  assign xb_d[1] = dl1_q[5*DDW +: DDW];
  assign xc_d1   = dl1_q[6*DDW +: DDW];

  // level B: p02, p13
  logic                 vb [2];
  logic                 eb [2];
  logic signed [DW-1:0] pb [2];
  for (genvar i = 0; i < 2; i++) begin : g_lb
    nev_cell #(.DW(DW)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(va[0] & va[1] & va[2]),
      .err_i(ea[i] | ea[i+1]),
      .a_i(pa[i]), .b_i(pa[i+1]), .da_i(db_d[i]), .db_i(db_d[i+2]),
      .den_i(xb_d[i]), .vld_o(vb[i]), .err_o(eb[i]), .p_o(pb[i])
    );
  end

  logic [3*DDW-1:0] dl2_q;
  nev_delay #(.W(3*DDW), .D(CLAT)) u_dl2 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({xc_d1, db_d[3], db_d[0]}),
    .q_o(dl2_q)
  );

  // level C: p03
  logic signed [DW-1:0] pc;
  nev_cell #(.DW(DW)) u_cell_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vb[0] & vb[1]), .err_i(eb[0] | eb[1]),
    .a_i(pb[0]), .b_i(pb[1]),
    .da_i($signed(dl2_q[0 +: DDW])), .db_i($signed(dl2_q[DDW +: DDW])),
    .den_i($signed(dl2_q[2*DDW +: DDW])),
    .vld_o(out_valid_o), .err_o(out_err_o), .p_o(pc)
  );
  assign out_data_o = pc;

  // in-flight tracking for the checks below
  logic [CW-1:0] fly_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fly_q <= '0;
    else         fly_q <= fly_q + CW'(in_valid_i) - CW'(out_valid_o);
  end

  // R7
  ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) in_valid_i |-> in_ready_o);
  // R7
  no_orphan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (fly_q != '0));
  // R6
  fly_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) fly_q <= CW'(LAT));
  // R4
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_err_o) |-> (out_data_o == '0));
  // R5
  err_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_err_o |-> out_valid_o);
endmodule

// File: tb/nev_interp_tb.sv
`timescale 1ns/1ps
module nev_interp_tb;
  localparam int LAT = 109;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] x_word = '0, y_word = '0;
  logic [15:0] xq = '0;
  logic        out_valid, out_err;
  logic [15:0] out_data;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  longint exp_d[$];
  bit     exp_e[$];
  int     exp_c[$];
  string  exp_t[$];

  always #2 clk = ~clk;

  nev_interp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .x_word_i(x_word), .y_word_i(y_word), .xq_i(xq),
    .out_valid_o(out_valid), .out_err_o(out_err), .out_data_o(out_data)
  );

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint ent(input longint a, b, da, db, den);
    return sat16((a * db - b * da) / den);
  endfunction

  function automatic void model(input logic [63:0] xw, yw, input logic [15:0] q,
                                output bit e, output longint r);
    longint x[4], y[4], d[4], p01, p12, p23, p02, p13;
    for (int i = 0; i < 4; i++) begin
      x[i] = longint'($signed(xw[16*i +: 16]));
      y[i] = longint'($signed(yw[16*i +: 16]));
      d[i] = longint'($signed(q)) - x[i];
    end
    e = (x[0]==x[1]) || (x[1]==x[2]) || (x[2]==x[3]) || (x[0]==x[2]) || (x[1]==x[3]) || (x[0]==x[3]);
    if (e) begin r = 0; return; end
    p01 = ent(y[0], y[1], d[0], d[1], x[0]-x[1]);
    p12 = ent(y[1], y[2], d[1], d[2], x[1]-x[2]);
    p23 = ent(y[2], y[3], d[2], d[3], x[2]-x[3]);
    p02 = ent(p01, p12, d[0], d[2], x[0]-x[2]);
    p13 = ent(p12, p23, d[1], d[3], x[1]-x[3]);
    r   = ent(p02, p13, d[0], d[3], x[0]-x[3]);
  endfunction

  function automatic logic [63:0] pk(input int a, b, c, d);
    return {16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic look();
    if (out_valid) begin
      if (exp_d.size() == 0) chk(1'b0, "R7 unrequested result", 1, 0);
      else begin
        longint ed = exp_d.pop_front();
        bit ee = exp_e.pop_front();
        int ec = exp_c.pop_front();
        string et = exp_t.pop_front();
        chk(cyc == ec + LAT, "R6 latency", cyc - ec, LAT);
        chk(longint'($signed(out_data)) == ed, et, longint'($signed(out_data)), ed);
        chk(out_err == ee, ee ? "R4 error flag" : "R5 error flag", out_err, ee);
      end
    end else if (exp_c.size() != 0 && exp_c[0] + LAT == cyc) begin
      chk(1'b0, "R6 missing result", 0, 1);
      void'(exp_d.pop_front()); void'(exp_e.pop_front());
      void'(exp_c.pop_front()); void'(exp_t.pop_front());
    end
  endtask

  task automatic step(input bit v, input logic [63:0] xw, yw, input logic [15:0] q,
                      input string tag);
    bit e; longint r;
    @(negedge clk);
    look();
    in_valid = v; x_word = xw; y_word = yw; xq = q;
    if (v) begin
      model(xw, yw, q, e, r);
      exp_d.push_back(r); exp_e.push_back(e); exp_c.push_back(cyc); exp_t.push_back(tag);
    end
    cyc++;
  endtask

  task automatic node_hit(input logic [63:0] xw, yw, input int lane);
    bit e; longint r;
    model(xw, yw, xw[16*lane +: 16], e, r);
    chk(r == longint'($signed(yw[16*lane +: 16])), "R3 bench model at node",
        r, longint'($signed(yw[16*lane +: 16])));
    step(1'b1, xw, yw, xw[16*lane +: 16], "R3 node value");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(out_valid == 1'b0, "R8 valid in reset", out_valid, 0);
    chk(out_err == 1'b0, "R8 err in reset", out_err, 0);
    chk(out_data == 16'd0, "R8 data in reset", out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R7 ready", in_ready, 1);

    // directed, back to back
    step(1'b1, pk(0, 10, 20, 30), pk(0, 20, 40, 60), 16'd15, "R2 linear");
    step(1'b1, pk(-7, 3, 11, 40), pk(100, -250, 900, 17), 16'd5, "R1 lane order");
    step(1'b1, pk(40, 11, 3, -7), pk(17, 900, -250, 100), 16'd5, "R1 lane order reversed");
    node_hit(pk(-50, -10, 25, 90), pk(1234, -3000, 777, 20000), 0);
    node_hit(pk(-50, -10, 25, 90), pk(1234, -3000, 777, 20000), 2);
    node_hit(pk(3, 8, 13, 29), pk(-32768, 32767, -5, 42), 3);
    step(1'b1, pk(5, 9, 9, 20), pk(1, 2, 3, 4), 16'd7, "R4 duplicate middle");
    step(1'b1, pk(5, 9, 14, 5), pk(100, 2, 3, 4), 16'd7, "R4 duplicate ends");
    step(1'b1, pk(0, 1, 2, 3), pk(30000, -30000, 30000, -30000), 16'hFF9C, "R9 clamp");
    step(1'b1, pk(0, 1, 2, 3), pk(-30000, 30000, -30000, 30000), 16'hFF9C, "R9 clamp neg");
    step(1'b1, pk(-32768, -100, 100, 32767), pk(32767, -32768, 32767, -32768), 16'd0, "R2 wide span");
    step(1'b0, '0, '0, '0, "");
    step(1'b1, pk(0, 2, 4, 6), pk(0, 4, 16, 36), 16'd3, "R2 square");

    // random bursts with gaps
    for (int n = 0; n < 600; n++) begin
      int xs[4], ys[4], q;
      xs[0] = int'($urandom_range(400)) - 200;
      for (int i = 1; i < 4; i++) xs[i] = xs[i-1] + int'($urandom_range(60, 1));
      if ($urandom_range(15) == 0) xs[$urandom_range(3, 1)] = xs[0];
      for (int i = 0; i < 4; i++)
        ys[i] = ($urandom_range(1) == 0) ? int'($urandom_range(4000)) - 2000
                                         : int'($urandom_range(65535)) - 32768;
      q = xs[0] - 20 + int'($urandom_range(xs[3] - xs[0] + 40));
      step($urandom_range(3) != 0, pk(xs[0], xs[1], xs[2], xs[3]),
           pk(ys[0], ys[1], ys[2], ys[3]), 16'(q), "R2 random");
    end

    repeat (LAT + 5) step(1'b0, '0, '0, '0, "");
    chk(exp_d.size() == 0, "R7 results outstanding", exp_d.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule